// File: doc/BRIEF.md
# Audio Output Power-Up and Mute Sequencer

This block governs the analog output stage of a stereo audio converter around reset. It counts sample-rate ticks (one pulse per frame of the left/right clock) and walks the output stage through a fixed order. While reset is held, the output buffers are detached and a soft current sink discharges the coupling capacitors. After reset is released, the outputs are clamped to ground for a fixed number of frames. A level code then climbs from zero to the quiescent midpoint over a long, evenly stepped ramp. Audio is passed only once that ramp has finished.

A mute flag for an external mute circuit is high whenever audio must not be heard: during reset, clamp and ramp, while a host mute request is present, and while the master-clock to frame-clock ratio is flagged invalid. Once the ramp has finished, a mute request or an invalid ratio only gates the audio. When the condition clears, audio resumes at the midpoint without ramping again. All timing is measured in ticks and not in clock cycles. Clock cycles without a tick do not advance any phase.

Top module: `dac_powerup_seq`

## Requirements
- R1: While rst_n is low, sink_en_o=1, clamp_o=0, audio_en_o=0, mute_o=1 and ramp_code_o=0; asserting rst_n low takes effect at once, without waiting for a clock edge.
- R2: One clock after rst_n rises, clamp_o=1 and sink_en_o=0. Clamping lasts exactly CLAMP_TICKS (1000) ticks, and in the cycle after the last of them clamp_o=0 with ramp_code_o still 0.
- R3: During the ramp, ramp_code_o rises by exactly one on every STEP_TICKS-th (100th) tick, counted from the end of the clamp. It is otherwise stable and never exceeds RAMP_TOP (100).
- R4: In the cycle after the RAMP_TOP*STEP_TICKS-th (10,000th) ramp tick, ramp_code_o=RAMP_TOP. If ratio_ok=1 and mute_req=0, audio_en_o=1 and mute_o=0 in that same cycle.
- R5: mute_o=1 and audio_en_o=0 throughout the clamp and the ramp, whatever the state of ratio_ok and mute_req.
- R6: During playback, ratio_ok=0 forces audio_en_o=0 and mute_o=1 in the same cycle. One clock after ratio_ok returns to 1, audio_en_o=1 again and ramp_code_o is still RAMP_TOP, with no new clamp or ramp.
- R7: During playback, mute_req=1 gates audio in the same way as R6. Audio resumes one clock after mute_req falls, without a new ramp.
- R8: Asserting rst_n low during playback immediately sets audio_en_o=0, sink_en_o=1, mute_o=1 and ramp_code_o=0.
- R9: Only clock cycles with lrck_tick=1 advance the clamp and ramp counts. Any number of cycles without a tick leaves the phase and the remaining count unchanged.
- R10: If the ramp ends while ratio_ok=0, audio stays off and mute_o stays 1 with ramp_code_o=RAMP_TOP. Audio starts one clock after ratio_ok becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset and power-down request |
| lrck_tick | input | 1 | Single-cycle pulse, one per sample frame |
| ratio_ok | input | 1 | High while the master-clock to frame-clock ratio is valid |
| mute_req | input | 1 | Host request to silence the output |
| clamp_o | output | 1 | Clamp outputs to ground |
| ramp_code_o | output | CODE_W (7) | Output level code, 0 up to RAMP_TOP |
| audio_en_o | output | 1 | Audio path enabled |
| sink_en_o | output | 1 | Soft discharge current sink enabled |
| mute_o | output | 1 | External mute control, high when silent |

## Verification
The hardest condition to reach from the ports is the end of the ramp, which needs 11,000 ticks. The difficulty grows when that end must coincide with an invalid clock ratio, or when a long gap without ticks must fall mid-clamp. The stimulus uses a tick task that pulses the tick input once per two clocks. Every count boundary is probed one tick before and exactly at the edge. A second full power-up runs entirely with the ratio flagged invalid, so the ramp ends straight into the muted state. Further cases cut into playback with a mute request, a ratio drop and an asynchronous reset.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_CLAMP = 3'd1,
        ST_RAMP  = 3'd2,
        ST_PLAY  = 3'd3,
        ST_MUTED = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/dps_tick_timer.sv
module dps_tick_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = run && tick && (tmr_q.cnt == CW'(LIMIT - 1));
        if (!run) begin
            tmr_d.cnt = '0;
        end else if (done) begin
            tmr_d.cnt = '0;
        end else if (tick) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tmr_q.cnt) < LIMIT);  // R9
    AST_TIMER_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(tmr_q.cnt));  // R9

endmodule

// File: rtl/dps_ramp.sv
module dps_ramp #(
    parameter int unsigned TOP = 100,
    parameter int unsigned CW  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] code,
    output logic          last
);
    typedef struct packed {
        logic [CW-1:0] code;
    } ramp_regs_t;

    ramp_regs_t ramp_d, ramp_q;

    always_comb begin
        ramp_d = ramp_q;
        last   = step && (ramp_q.code == CW'(TOP - 1));
        if (step && (ramp_q.code < CW'(TOP))) begin
            ramp_d.code = ramp_q.code + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_q <= '0;
        end else begin
            ramp_q <= ramp_d;
        end
    end

    assign code = ramp_q.code;

    AST_RAMP_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ramp_q.code) <= TOP);  // R3
    AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ramp_q.code));  // R3
    AST_RAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (32'(ramp_q.code) < TOP)) |=> (ramp_q.code == $past(ramp_q.code) + 1'b1));  // R3

endmodule

// File: rtl/dac_powerup_seq.sv
module dac_powerup_seq #(
    parameter  int unsigned CLAMP_TICKS = 1000,
    parameter  int unsigned RAMP_TOP    = 100,
    parameter  int unsigned STEP_TICKS  = 100,
    localparam int unsigned CODE_W      = $clog2(RAMP_TOP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lrck_tick,
    input  logic              ratio_ok,
    input  logic              mute_req,
    output logic              clamp_o,
    output logic [CODE_W-1:0] ramp_code_o,
    output logic              audio_en_o,
    output logic              sink_en_o,
    output logic              mute_o
);
    import dps_pkg::*;

    seq_regs_t seq_d, seq_q;
    logic      clamp_done;
    logic      step_done;
    logic      ramp_last;
    logic      play_ok;

    dps_tick_timer #(.LIMIT(CLAMP_TICKS)) u_clamp_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_q.state == ST_CLAMP),
        .tick  (lrck_tick),
        .done  (clamp_done)
    );

    dps_tick_timer #(.LIMIT(STEP_TICKS)) u_step_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_q.state == ST_RAMP),
        .tick  (lrck_tick),
        .done  (step_done)
    );

    dps_ramp #(.TOP(RAMP_TOP), .CW(CODE_W)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_done),
        .code  (ramp_code_o),
        .last  (ramp_last)
    );

    assign play_ok = ratio_ok && !mute_req;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_RESET: seq_d.state = ST_CLAMP;
            ST_CLAMP: if (clamp_done) seq_d.state = ST_RAMP;
            ST_RAMP:  if (ramp_last)  seq_d.state = play_ok ? ST_PLAY : ST_MUTED;
            ST_PLAY:  if (!play_ok)   seq_d.state = ST_MUTED;
            ST_MUTED: if (play_ok)    seq_d.state = ST_PLAY;
            default:  seq_d.state = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        clamp_o    = (seq_q.state == ST_CLAMP);
        sink_en_o  = (seq_q.state == ST_RESET);
        audio_en_o = (seq_q.state == ST_PLAY) && play_ok;
        mute_o     = !audio_en_o;
    end

    AST_CLAMP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_o |-> (ramp_code_o == '0));  // R2
    AST_CLAMP_EXIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_o) |-> (ramp_code_o == '0) && !audio_en_o);  // R2
    AST_AUDIO_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
        audio_en_o |-> (ramp_code_o == CODE_W'(RAMP_TOP)));  // R4
    AST_RATIO_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_ok |-> (mute_o && !audio_en_o));  // R6
    AST_HOST_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req |-> (mute_o && !audio_en_o));  // R7
    AST_SINK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        sink_en_o |-> (!clamp_o && !audio_en_o));  // R8

endmodule

// File: tb/dac_powerup_seq_bench.sv
module dac_powerup_seq_bench;

    localparam int N_CLAMP = 1000;
    localparam int N_STEP  = 100;
    localparam int N_TOP   = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrck_tick = 1'b0;
    logic       ratio_ok = 1'b1;
    logic       mute_req = 1'b0;
    logic       clamp_o;
    logic [6:0] ramp_code_o;
    logic       audio_en_o;
    logic       sink_en_o;
    logic       mute_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    dac_powerup_seq u_dac_powerup_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .lrck_tick   (lrck_tick),
        .ratio_ok    (ratio_ok),
        .mute_req    (mute_req),
        .clamp_o     (clamp_o),
        .ramp_code_o (ramp_code_o),
        .audio_en_o  (audio_en_o),
        .sink_en_o   (sink_en_o),
        .mute_o      (mute_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) lrck_tick = 1'b1;
            @(negedge clk) lrck_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset_state;
        @(negedge clk) rst_n = 1'b0;
        idle(3);
        chk("R1 sink in reset", int'(sink_en_o), 1);
        chk("R1 clamp in reset", int'(clamp_o), 0);
        chk("R1 audio in reset", int'(audio_en_o), 0);
        chk("R1 mute in reset", int'(mute_o), 1);
        chk("R1 code in reset", int'(ramp_code_o), 0);
    endtask

    task automatic powerup(input logic ok);
        @(negedge clk) rst_n = 1'b0;
        ratio_ok = ok;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 clamp after release", int'(clamp_o), 1);
        chk("R2 sink off after release", int'(sink_en_o), 0);
        ticks(N_CLAMP / 2);
        idle(40);
        chk("R9 clamp held across gap", int'(clamp_o), 1);
        ticks(N_CLAMP / 2 - 1);
        chk("R2 clamp one tick before end", int'(clamp_o), 1);
        chk("R5 mute during clamp", int'(mute_o), 1);
        ticks(1);
        chk("R2 clamp released", int'(clamp_o), 0);
        chk("R2 code zero at ramp start", int'(ramp_code_o), 0);
        ticks(N_STEP - 1);
        chk("R3 code before first step", int'(ramp_code_o), 0);
        ticks(1);
        chk("R3 first step", int'(ramp_code_o), 1);
        idle(25);
        chk("R9 code held without ticks", int'(ramp_code_o), 1);
        ticks(N_STEP * (N_TOP - 1) - 1);
        chk("R3 code before last step", int'(ramp_code_o), N_TOP - 1);
        chk("R5 audio off during ramp", int'(audio_en_o), 0);
        chk("R5 mute during ramp", int'(mute_o), 1);
        ticks(1);
        chk("R4 code at midpoint", int'(ramp_code_o), N_TOP);
    endtask

    task automatic t_powerup_play;
        mute_req = 1'b0;
        powerup(1'b1);
        chk("R4 audio on", int'(audio_en_o), 1);
        chk("R4 mute off", int'(mute_o), 0);
        ticks(300);
        chk("R3 code saturated", int'(ramp_code_o), N_TOP);
    endtask

    task automatic t_ratio_drop;
        @(negedge clk) ratio_ok = 1'b0;
        #1;
        chk("R6 audio gated at once", int'(audio_en_o), 0);
        chk("R6 mute raised at once", int'(mute_o), 1);
        ticks(5);
        chk("R6 code held while muted", int'(ramp_code_o), N_TOP);
        chk("R6 no clamp while muted", int'(clamp_o), 0);
        @(negedge clk) ratio_ok = 1'b1;
        @(negedge clk);
        chk("R6 audio resumed", int'(audio_en_o), 1);
        chk("R6 no re-ramp", int'(ramp_code_o), N_TOP);
    endtask

    task automatic t_host_mute;
        @(negedge clk) mute_req = 1'b1;
        #1;
        chk("R7 audio gated", int'(audio_en_o), 0);
        chk("R7 mute raised", int'(mute_o), 1);
        ticks(3);
        @(negedge clk) mute_req = 1'b0;
        @(negedge clk);
        chk("R7 audio resumed", int'(audio_en_o), 1);
        chk("R7 mute cleared", int'(mute_o), 0);
        chk("R7 no re-ramp", int'(ramp_code_o), N_TOP);
    endtask

    task automatic t_reset_in_play;
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk("R8 audio off on reset", int'(audio_en_o), 0);
        chk("R8 sink on on reset", int'(sink_en_o), 1);
        chk("R8 mute on reset", int'(mute_o), 1);
        chk("R8 code cleared", int'(ramp_code_o), 0);
    endtask

    task automatic t_ratio_bad_ramp;
        powerup(1'b0);
        chk("R10 audio off at ramp end", int'(audio_en_o), 0);
        chk("R10 mute at ramp end", int'(mute_o), 1);
        @(negedge clk) ratio_ok = 1'b1;
        #1;
        chk("R10 audio waits a clock", int'(audio_en_o), 0);
        @(negedge clk);
        chk("R10 audio starts", int'(audio_en_o), 1);
        chk("R10 code at midpoint", int'(ramp_code_o), N_TOP);
    endtask

    initial begin
        t_reset_state();
        t_powerup_play();
        t_ratio_drop();
        t_host_mute();
        t_reset_in_play();
        t_ratio_bad_ramp();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule